// File: doc/BRIEF.md
# Segment Operand Access Checker

This block judges a single memory operand reference against the cached descriptor of the segment the reference goes through. The address stage supplies several items: the access direction, the 16-bit effective offset, the operand length, the segment's cached rights byte, its 16-bit limit, its selector, and a flag that marks the stack segment register. These are presented together with a one-cycle strobe. From them the block decides whether the reference is legal. If it is not, the block reports an exception vector and an error code for the exception stacking logic.

Type rules are checked first. No code segment may be written. A code segment may be read only when it is readable. A data segment may be written only when it is writable. Bounds are checked after the type rules, and expand-down data segments use an inverted bound. The offset sum wraps at 64 Ki and never faults by itself. A bound fault on the stack segment uses the stack vector, and every other fault uses the general protection vector. The verdict is registered on the clock edge that samples the strobe, and it stays unchanged until the next strobe.

Top module: `seg_access_check`

## Requirements
- R1: Rights byte fields: bit 4 set means code/data, bit 3 executable, bit 2 expand-down for data, bit 1 writable for data or readable for code. A write to a segment with bits 4 and 3 set faults with vector 13.
- R2: A read from a code segment (bit 4 set, bit 3 set) with bit 1 clear faults with vector 13.
- R3: A write to a data segment (bit 4 set, bit 3 clear) with bit 1 clear faults with vector 13.
- R4: For a segment that is not expand-down, the operand spans offset to offset+size_i, where size_i is the byte count minus one. A bound fault occurs when the offset exceeds the limit or when that end offset exceeds the limit.
- R5: The end offset is taken modulo 65536, so a sum that carries past 0xFFFF causes no fault when the wrapped end offset is within the limit.
- R6: For an expand-down data segment (bits 4,3,2 = 1,0,1), a bound fault occurs when the offset is less than or equal to the limit, and otherwise there is no bound fault.
- R7: A bound fault reports vector 12 when ss_i is set and vector 13 otherwise, always with error code 0.
- R8: A type fault (R1 to R3, or bit 4 clear) reports error code sel_i with bits 1:0 cleared. A type fault takes precedence over a bound fault.
- R9: When there is no fault, and after reset, fault_o is 0, vector_o is 0 and err_code_o is 0.
- R10: The verdict appears on the clock edge that samples valid_i high. It holds while valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Strobe: evaluate the inputs this cycle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| offset_i | input | 16 | Effective offset of the operand |
| size_i | input | 2 | Operand byte count minus one |
| rights_i | input | 8 | Cached access-rights byte |
| limit_i | input | 16 | Cached segment limit |
| ss_i | input | 1 | Reference goes through the stack segment |
| sel_i | input | 16 | Selector of the segment |
| fault_o | output | 1 | Registered fault flag |
| vector_o | output | 8 | Registered exception vector, 0 when no fault |
| err_code_o | output | 16 | Registered error code |

## Verification
All three results are due at the first rising edge after a cycle in which valid_i is high. They remain constant while no further strobe arrives. The bench drives inputs on the falling edge and updates its behavioural expectation only for strobed cycles at the following rising edge. It compares every output at the next falling edge, so each comparison falls exactly one register stage after the stimulus. Idle cycles are compared too, which confirms that the held verdict does not drift.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       is_seg;
    logic       exec;
    logic       dir_conf;
    logic       rw;
    logic       accessed;
  } rights_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TYPE  = 2'd1,
    FLT_BOUND = 2'd2
  } flt_e;

endpackage

// File: rtl/seg_rights_decode.sv
module seg_rights_decode
  import seg_chk_pkg::*;
(
  input  rights_t rights_i,
  input  logic    write_i,
  output logic    type_flt_o,
  output logic    expand_down_o
);

  logic code_seg, data_seg;

  always_comb begin
    code_seg      = rights_i.is_seg &  rights_i.exec;
    data_seg      = rights_i.is_seg & ~rights_i.exec;
    expand_down_o = data_seg & rights_i.dir_conf;
    type_flt_o    = 1'b0;
    if (!rights_i.is_seg)                type_flt_o = 1'b1;
    else if (code_seg && write_i)        type_flt_o = 1'b1;
    else if (code_seg && !rights_i.rw)   type_flt_o = 1'b1;
    else if (data_seg && write_i && !rights_i.rw) type_flt_o = 1'b1;
  end

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 2
) (
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [OFS_W-1:0]  limit_i,
  input  logic              expand_down_i,
  output logic              bound_flt_o
);

  // end offset wraps at 2**OFS_W: carry is discarded
  logic [OFS_W-1:0] end_ofs;

  always_comb begin
    end_ofs = offset_i + OFS_W'(size_i);
    if (expand_down_i) bound_flt_o = (offset_i <= limit_i);
    else               bound_flt_o = (offset_i > limit_i) || (end_ofs > limit_i);
  end

endmodule

// File: rtl/seg_verdict_reg.sv
module seg_verdict_reg
  import seg_chk_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int SEL_W  = 16,
  parameter int SS_VEC = 12,
  parameter int GP_VEC = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             type_flt_i,
  input  logic             bound_flt_i,
  input  logic             ss_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fault_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [SEL_W-1:0] err_code_o
);

  flt_e             kind;
  logic [VEC_W-1:0] vec_d;
  logic [SEL_W-1:0] code_d;

  always_comb begin
    if (type_flt_i)       kind = FLT_TYPE;
    else if (bound_flt_i) kind = FLT_BOUND;
    else                  kind = FLT_NONE;
    unique case (kind)
      FLT_TYPE: begin
        vec_d  = VEC_W'(GP_VEC);
        code_d = {sel_i[SEL_W-1:2], 2'b00};
      end
      FLT_BOUND: begin
        vec_d  = ss_i ? VEC_W'(SS_VEC) : VEC_W'(GP_VEC);
        code_d = '0;
      end
      default: begin
        vec_d  = '0;
        code_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o    <= 1'b0;
      vector_o   <= '0;
      err_code_o <= '0;
    end else if (valid_i) begin
      fault_o    <= (kind != FLT_NONE);
      vector_o   <= vec_d;
      err_code_o <= code_d;
    end
  end

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 2,
  parameter int SEL_W  = 16,
  parameter int VEC_W  = 8,
  parameter int SS_VEC = 12,
  parameter int GP_VEC = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [7:0]        rights_i,
  input  logic [OFS_W-1:0]  limit_i,
  input  logic              ss_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              fault_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [SEL_W-1:0]  err_code_o
);

  rights_t rights;
  logic    type_flt, expand_down, bound_flt;

  assign rights = rights_t'(rights_i);

  seg_rights_decode u_rights (
    .rights_i      (rights),
    .write_i       (write_i),
    .type_flt_o    (type_flt),
    .expand_down_o (expand_down)
  );

  seg_limit_check #(.OFS_W(OFS_W), .SIZE_W(SIZE_W)) u_limit (
    .offset_i      (offset_i),
    .size_i        (size_i),
    .limit_i       (limit_i),
    .expand_down_i (expand_down),
    .bound_flt_o   (bound_flt)
  );

  seg_verdict_reg #(
    .VEC_W(VEC_W), .SEL_W(SEL_W), .SS_VEC(SS_VEC), .GP_VEC(GP_VEC)
  ) u_verdict (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .type_flt_i  (type_flt),
    .bound_flt_i (bound_flt),
    .ss_i        (ss_i),
    .sel_i       (sel_i),
    .fault_o     (fault_o),
    .vector_o    (vector_o),
    .err_code_o  (err_code_o)
  );

endmodule

// File: rtl/seg_access_check_sva.sv
module seg_access_check_sva #(
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 2,
  parameter int SEL_W  = 16,
  parameter int VEC_W  = 8,
  parameter int SS_VEC = 12,
  parameter int GP_VEC = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              write_i,
  input logic [OFS_W-1:0]  offset_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [7:0]        rights_i,
  input logic [OFS_W-1:0]  limit_i,
  input logic              ss_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              fault_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic [SEL_W-1:0]  err_code_o
);

  a_r1_code_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && write_i && rights_i[4] && rights_i[3]
    |=> fault_o && vector_o == VEC_W'(GP_VEC));

  a_r8_system_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !rights_i[4]
    |=> fault_o && err_code_o == {$past(sel_i[SEL_W-1:2]), 2'b00});

  a_r9_clean_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> vector_o == '0 && err_code_o == '0);

  a_r7_stack_vec_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && vector_o == VEC_W'(SS_VEC) |-> err_code_o == '0);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(fault_o) && $stable(vector_o) && $stable(err_code_o));

endmodule

bind seg_access_check seg_access_check_sva #(
  .OFS_W(OFS_W), .SIZE_W(SIZE_W), .SEL_W(SEL_W),
  .VEC_W(VEC_W), .SS_VEC(SS_VEC), .GP_VEC(GP_VEC)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .write_i(write_i),
  .offset_i(offset_i), .size_i(size_i), .rights_i(rights_i),
  .limit_i(limit_i), .ss_i(ss_i), .sel_i(sel_i),
  .fault_o(fault_o), .vector_o(vector_o), .err_code_o(err_code_o)
);

// File: tb/seg_access_check_tb.sv
module seg_access_check_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [15:0] offset = '0;
  logic [1:0]  size = '0;
  logic [7:0]  rights = '0;
  logic [15:0] limit = '0;
  logic        ss = 1'b0;
  logic [15:0] sel = '0;
  logic        fault;
  logic [7:0]  vector;
  logic [15:0] err_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic        e_fault = 1'b0;
  logic [7:0]  e_vec = '0;
  logic [15:0] e_code = '0;

  always #4 clk = ~clk;

  seg_access_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .write_i(write),
    .offset_i(offset), .size_i(size), .rights_i(rights), .limit_i(limit),
    .ss_i(ss), .sel_i(sel), .fault_o(fault), .vector_o(vector),
    .err_code_o(err_code)
  );

  // behavioural reference
  task automatic model();
    int  end_ofs;
    bit  type_bad, bound_bad;
    end_ofs  = (int'(offset) + int'(size)) % 65536;
    type_bad = 0;
    if (!rights[4]) type_bad = 1;
    else if (rights[3]) type_bad = write || !rights[1];
    else type_bad = write && !rights[1];
    if (rights[4] && !rights[3] && rights[2]) bound_bad = (int'(offset) <= int'(limit));
    else bound_bad = (int'(offset) > int'(limit)) || (end_ofs > int'(limit));
    if (type_bad) begin
      e_fault = 1; e_vec = 13; e_code = sel & 16'hFFFC;
    end else if (bound_bad) begin
      e_fault = 1; e_vec = ss ? 8'd12 : 8'd13; e_code = 0;
    end else begin
      e_fault = 0; e_vec = 0; e_code = 0;
    end
  endtask

  task automatic check(string tag);
    n_chk++;
    if (fault !== e_fault || vector !== e_vec || err_code !== e_code) begin
      n_bad++;
      $display("FAIL %s: got fault=%0b vec=%0d code=%h, exp fault=%0b vec=%0d code=%h",
               tag, fault, vector, err_code, e_fault, e_vec, e_code);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(bit v, bit w, logic [15:0] o, logic [1:0] s, logic [7:0] r,
                      logic [15:0] l, bit stk, logic [15:0] sl, string tag);
    valid = v; write = w; offset = o; size = s; rights = r; limit = l; ss = stk; sel = sl;
    @(posedge clk);
    if (v) model();
    @(negedge clk);
    valid = 0;
    check(tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset");
    // rights: 0x9A readable code, 0x98 exec-only code, 0x92 rw data, 0x90 ro data, 0x96 rw expand-down
    step(1, 0, 16'h0010, 1, 8'h9A, 16'h00FF, 0, 16'h0023, "R9 readable code read ok");
    step(1, 0, 16'h0010, 1, 8'h98, 16'h00FF, 0, 16'h0023, "R2 exec-only read");
    step(1, 1, 16'h0010, 0, 8'h9A, 16'h00FF, 0, 16'h0047, "R1 code write");
    step(1, 1, 16'h0010, 0, 8'h90, 16'h00FF, 0, 16'h0052, "R3 read-only write");
    step(1, 1, 16'h0010, 1, 8'h92, 16'h00FF, 0, 16'h0052, "R9 writable data ok");
    step(1, 0, 16'h00FE, 1, 8'h92, 16'h00FF, 0, 16'h0052, "R4 end equals limit ok");
    step(1, 0, 16'h00FF, 1, 8'h92, 16'h00FF, 0, 16'h0052, "R4 end past limit");
    step(1, 0, 16'h0100, 0, 8'h92, 16'h00FF, 1, 16'h0052, "R7 stack bound vec 12");
    step(1, 0, 16'h0100, 0, 8'h92, 16'h00FF, 0, 16'h0052, "R7 data bound vec 13");
    step(1, 0, 16'hFFFF, 1, 8'h92, 16'hFFFF, 0, 16'h0052, "R5 wrapped end ok");
    step(1, 0, 16'hFFFE, 3, 8'h92, 16'hFFFF, 0, 16'h0052, "R5 wrapped dword ok");
    step(1, 0, 16'h00FF, 1, 8'h96, 16'h00FF, 1, 16'h0052, "R6 expand-down at limit");
    step(1, 0, 16'h0100, 1, 8'h96, 16'h00FF, 1, 16'h0052, "R6 expand-down above ok");
    step(1, 1, 16'h0200, 0, 8'h90, 16'h00FF, 0, 16'h1237, "R8 type beats bound");
    step(1, 0, 16'h0000, 0, 8'h82, 16'hFFFF, 0, 16'hABCF, "R8 system descriptor");
    step(1, 0, 16'h0100, 0, 8'h92, 16'h00FF, 0, 16'h0052, "R10 set fault");
    for (int i = 0; i < 4; i++)
      step(0, 0, 16'h0000, 0, 8'h92, 16'hFFFF, 0, 16'h0000, "R10 hold idle");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] r;
      r = 8'h80 | 8'($urandom_range(0, 31));
      if ($urandom_range(0, 7) == 0) r[4] = 0;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           16'($urandom_range(0, 65535)), 2'($urandom_range(0, 3)), r,
           16'($urandom_range(0, 65535)), $urandom_range(0, 1) == 1,
           16'($urandom_range(0, 65535)), "R4 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule